// File: doc/BRIEF.md
# Packet Timeout Recovery Watchdog

This block watches a framed, word-wide link stream and bounds how much data a control-path upset can destroy. A start-of-packet word arms it. From then on it totals the bytes of every accepted word that follows. A normal end-of-packet disarms it. If the byte total reaches the configured budget before the packet ends, the block sends a one-cycle recovery pulse toward the clean-up logic. It then enters a discard mode.

While in discard mode, every incoming word is marked for dropping, because it cannot be tied to a known packet. This lasts until a word carrying a framing character arrives. That word ends discard mode and is itself kept. If it also carries a start-of-packet, it arms the watchdog again. A downstream stage uses the per-word keep indication to gate its writes, and it uses the recovery pulse to reset its own control state.

Top module: `pkt_budget_watchdog`

## Requirements
- R1: After reset `trig_o` and `drop_o` are 0, and `keep_o` equals `vld_i`.
- R2: A word with `vld_i` and `sop_i` high (and `eop_i` low) arms the watchdog with a byte total of zero. The SOP word's own bytes are not counted.
- R3: A word with `eop_i` high ends an armed packet. No recovery pulse follows, however many unframed words come later.
- R4: A new SOP word while armed restarts the byte total from zero.
- R5: Only cycles with `vld_i` high add to the total, each adding `BYTES_PER_WORD`. Idle cycles leave it unchanged. With the defaults (4 bytes, budget 64) the 16th body word after the SOP word is the expiring one.
- R6: On expiry `trig_o` is high for exactly one cycle, the cycle after the expiring word. `drop_o` rises in that same cycle.
- R7: While `drop_o` is high, a word without `frame_i` gets `keep_o` = 0, and its `sop_i`/`eop_i` are ignored (no arming, no further pulse).
- R8: A valid word with `frame_i` high during discard mode gets `keep_o` = 1, and `drop_o` is 0 from the next cycle. If that word also has `sop_i`, it arms the watchdog.
- R9: If the word that would reach the budget carries `eop_i`, the packet completes and no pulse is produced.
- R10: If the word that would reach the budget carries `sop_i`, the count restarts and no pulse is produced.
- R11: A word with both `sop_i` and `eop_i` is a complete packet and leaves the watchdog disarmed.
- R12: Body or EOP words that arrive while disarmed and outside discard mode change nothing and are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | A word is present this cycle |
| sop_i | input | 1 | Word begins a packet |
| eop_i | input | 1 | Word ends a packet |
| frame_i | input | 1 | Word carries a framing character |
| trig_o | output | 1 | One-cycle recovery request |
| drop_o | output | 1 | Discard mode is active |
| keep_o | output | 1 | Current word should be passed downstream |

## Verification
Two events can land on the same word: the byte budget expiring, and a packet boundary (an end-of-packet or a fresh start-of-packet). The bench drives exactly 15 body words after an SOP, then puts `eop_i` or `sop_i` on the 16th word. A correct design shows no recovery pulse and no discard mode in the following cycle. In the SOP case, a further 16 body words must then produce the pulse. A second overlap is a framing word that both ends discard mode and starts a packet; the bench judges it by checking that a later timeout occurs.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

   // classification of one accepted word, as seen by the byte-budget counter
   typedef enum logic [2:0] {
      EV_IDLE   = 3'd0,
      EV_START  = 3'd1,
      EV_SINGLE = 3'd2,
      EV_END    = 3'd3,
      EV_BODY   = 3'd4
   } pbw_ev_e;

   function automatic int unsigned pbw_cnt_width(input int unsigned budget,
                                                 input int unsigned bpw);
      return $clog2(budget + bpw + 1);
   endfunction

endpackage

// File: rtl/pbw_classify.sv
module pbw_classify
   import pbw_pkg::*;
(
   input  logic    vld_i,
   input  logic    sop_i,
   input  logic    eop_i,
   input  logic    frame_i,
   input  logic    drop_q_i,
   output pbw_ev_e ev_o,
   output logic    resync_o,
   output logic    keep_o
);

   logic accept;

   // in discard mode only a framing word gets through
   assign accept   = vld_i & (~drop_q_i | frame_i);
   assign resync_o = vld_i & drop_q_i & frame_i;
   assign keep_o   = accept;

   always_comb begin
      if (!accept)              ev_o = EV_IDLE;
      else if (sop_i && eop_i)  ev_o = EV_SINGLE;
      else if (sop_i)           ev_o = EV_START;
      else if (eop_i)           ev_o = EV_END;
      else                      ev_o = EV_BODY;
   end

endmodule

// File: rtl/pbw_budget.sv
module pbw_budget
   import pbw_pkg::*;
#(
   parameter int unsigned BYTES_PER_WORD = 4,
   parameter int unsigned BYTE_BUDGET    = 64
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pbw_ev_e ev_i,
   output logic    expire_o
);

   localparam int unsigned CW = pbw_cnt_width(BYTE_BUDGET, BYTES_PER_WORD);
   localparam logic [CW-1:0] STEP  = CW'(BYTES_PER_WORD);
   localparam logic [CW-1:0] LIMIT = CW'(BYTE_BUDGET);

   logic          armed_q, armed_d;
   logic [CW-1:0] cnt_q, cnt_d, sum;

   assign sum      = cnt_q + STEP;
   assign expire_o = armed_q && (ev_i == EV_BODY) && (sum >= LIMIT);

   always_comb begin
      armed_d = armed_q;
      cnt_d   = cnt_q;
      unique case (ev_i)
         EV_START: begin
            armed_d = 1'b1;
            cnt_d   = '0;
         end
         EV_SINGLE, EV_END: begin
            armed_d = 1'b0;
            cnt_d   = '0;
         end
         EV_BODY: begin
            if (armed_q) begin
               if (expire_o) begin
                  armed_d = 1'b0;
                  cnt_d   = '0;
               end else begin
                  cnt_d = sum;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         armed_q <= armed_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/pbw_drop.sv
module pbw_drop (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic resync_i,
   output logic drop_q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)        drop_q_o <= 1'b0;
      else if (expire_i) drop_q_o <= 1'b1;
      else if (resync_i) drop_q_o <= 1'b0;
   end

endmodule

// File: rtl/pkt_budget_watchdog.sv
module pkt_budget_watchdog
   import pbw_pkg::*;
#(
   parameter int unsigned BYTES_PER_WORD = 4,
   parameter int unsigned BYTE_BUDGET    = 64,
   parameter bit          TRIG_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic sop_i,
   input  logic eop_i,
   input  logic frame_i,
   output logic trig_o,
   output logic drop_o,
   output logic keep_o
);

   if (BYTES_PER_WORD < 1) begin : g_bad_bpw
      $error("BYTES_PER_WORD must be at least 1");
   end
   if (BYTE_BUDGET < BYTES_PER_WORD) begin : g_bad_budget
      $error("BYTE_BUDGET must cover at least one word");
   end

   pbw_ev_e ev;
   logic    resync, expire, drop_q;

   pbw_classify u_cls (
      .vld_i    (vld_i),
      .sop_i    (sop_i),
      .eop_i    (eop_i),
      .frame_i  (frame_i),
      .drop_q_i (drop_q),
      .ev_o     (ev),
      .resync_o (resync),
      .keep_o   (keep_o)
   );

   pbw_budget #(
      .BYTES_PER_WORD (BYTES_PER_WORD),
      .BYTE_BUDGET    (BYTE_BUDGET)
   ) u_bud (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .expire_o (expire)
   );

   pbw_drop u_drp (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .resync_i (resync),
      .drop_q_o (drop_q)
   );

   assign drop_o = drop_q;

   if (TRIG_REGISTERED) begin : g_trig_reg
      logic trig_q;
      always_ff @(posedge clk) begin
         if (!rst_n) trig_q <= 1'b0;
         else        trig_q <= expire;
      end
      assign trig_o = trig_q;
   end else begin : g_trig_comb
      assign trig_o = expire;
   end

endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
   parameter bit TRIG_REGISTERED = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic vld_i,
   input logic frame_i,
   input logic trig_o,
   input logic drop_o,
   input logic keep_o
);

   // R6: the recovery request never lasts two cycles
   a_r6_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   // R7: discard mode persists until a framing word arrives
   a_r7_hold_drop: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o && !(vld_i && frame_i) |=> drop_o);

   // R7: unframed words are not kept in discard mode
   a_r7_no_keep: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o && !frame_i |-> !keep_o);

   // R8: a framing word leaves discard mode on the next cycle
   a_r8_resync_exit: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o && vld_i && frame_i |=> !drop_o);

   if (TRIG_REGISTERED) begin : g_reg
      // R6: discard mode starts together with the pulse
      a_r6_drop_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(drop_o) |-> trig_o);
      // R5: an idle cycle cannot expire the budget
      a_r5_idle_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
         !vld_i |=> !trig_o);
      // R7: no new pulse while discard mode is already set
      a_r7_no_retrig: assert property (@(posedge clk) disable iff (!rst_n)
         drop_o |=> !trig_o);
   end else begin : g_comb
      a_r7_no_retrig: assert property (@(posedge clk) disable iff (!rst_n)
         trig_o |-> !drop_o);
      a_r5_idle_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
         !vld_i |-> !trig_o);
   end

endmodule

bind pkt_budget_watchdog pbw_checker #(
   .TRIG_REGISTERED (TRIG_REGISTERED)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .vld_i   (vld_i),
   .frame_i (frame_i),
   .trig_o  (trig_o),
   .drop_o  (drop_o),
   .keep_o  (keep_o)
);

// File: tb/pkt_budget_watchdog_tb_top.sv
module pkt_budget_watchdog_tb_top;

   localparam int BPW = 4;
   localparam int BUD = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0, sop = 1'b0, eop = 1'b0, frm = 1'b0;
   logic trig, drop, keep;

   int checks = 0;
   int failures = 0;
   int trig_seen = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference state, built from the requirements
   bit m_drop = 0, m_armed = 0, m_trig = 0;
   int m_cnt = 0;

   bit [2:0] q_val[$];
   string    q_tag[$];

   always #10 clk = ~clk;   // 50 MHz

   pkt_budget_watchdog #(
      .BYTES_PER_WORD (BPW),
      .BYTE_BUDGET    (BUD)
   ) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (vld),
      .sop_i   (sop),
      .eop_i   (eop),
      .frame_i (frm),
      .trig_o  (trig),
      .drop_o  (drop),
      .keep_o  (keep)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: one word per cycle, expected result pushed to the scoreboard
   task automatic word(input bit v, input bit s, input bit e, input bit f);
      bit acc, k, tn;
      @(posedge clk);
      #5;
      vld = v; sop = s; eop = e; frm = f;
      acc = v && (!m_drop || f);
      k = acc;
      q_val.push_back({k, m_trig, m_drop});
      q_tag.push_back(cur_req);
      tn = 0;
      if (v && m_drop && f) m_drop = 0;
      if (acc) begin
         if (s) begin
            m_armed = !e;
            m_cnt = 0;
         end else if (e) begin
            m_armed = 0;
            m_cnt = 0;
         end else if (m_armed) begin
            m_cnt += BPW;
            if (m_cnt >= BUD) begin
               tn = 1; m_drop = 1; m_armed = 0; m_cnt = 0;
            end
         end
      end
      m_trig = tn;
   endtask

   task automatic body(input int n);
      for (int i = 0; i < n; i++) word(1, 0, 0, 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) word(0, 0, 0, 0);
   endtask

   task automatic expect_pulses(input string req, input int n);
      idle(2);
      check(req, "recovery pulse count", trig_seen, n);
      trig_seen = 0;
   endtask

   // monitor: pops expected items and compares, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #15;
         if (trig) trig_seen++;
         if (q_val.size() > 0) begin
            bit [2:0] e;
            string t;
            e = q_val.pop_front();
            t = q_tag.pop_front();
            check(t, "keep_o", keep, e[2]);
            check(t, "trig_o", trig, e[1]);
            check(t, "drop_o", drop, e[0]);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #15;
      check("R1", "trig_o in reset", trig, 0);
      check("R1", "drop_o in reset", drop, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1"; idle(1); word(1, 0, 0, 0);
      trig_seen = 0;

      // R2 R5: arm, body words with idle gaps, expire on 16th body word
      cur_req = "R2";
      word(1, 1, 0, 1);
      cur_req = "R5";
      for (int i = 0; i < 15; i++) begin
         word(1, 0, 0, 0);
         idle(1);
      end
      cur_req = "R6";
      word(1, 0, 0, 0);
      expect_pulses("R6", 1);

      // R7: discard mode ignores unframed SOP/EOP
      cur_req = "R7";
      word(1, 1, 0, 0); body(20); word(1, 0, 1, 0);
      expect_pulses("R7", 0);

      // R8: framing SOP word ends discard and arms again
      cur_req = "R8";
      word(1, 1, 0, 1); body(16);
      expect_pulses("R8", 1);
      word(1, 0, 0, 1); body(2);

      // R3: completed packet, later words never time out
      cur_req = "R3";
      word(1, 1, 0, 1); body(5); word(1, 0, 1, 0); body(30);
      expect_pulses("R3", 0);

      // R4: restart mid-packet
      cur_req = "R4";
      word(1, 1, 0, 1); body(10); word(1, 1, 0, 1); body(15);
      expect_pulses("R4", 0);
      body(1);
      expect_pulses("R4", 1);
      word(1, 0, 0, 1);

      // R9: EOP on the budget word wins
      cur_req = "R9";
      word(1, 1, 0, 1); body(15); word(1, 0, 1, 0); body(20);
      expect_pulses("R9", 0);

      // R10: SOP on the budget word restarts
      cur_req = "R10";
      word(1, 1, 0, 1); body(15); word(1, 1, 0, 1); body(15);
      expect_pulses("R10", 0);
      body(1);
      expect_pulses("R10", 1);
      word(1, 0, 0, 1);

      // R11: single-word packet does not arm
      cur_req = "R11";
      word(1, 1, 1, 1); body(20);
      expect_pulses("R11", 0);

      // R12: stray words while disarmed
      cur_req = "R12";
      word(1, 0, 1, 0); body(20); word(1, 0, 0, 1);
      expect_pulses("R12", 0);

      idle(2);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule